// File: doc/BRIEF.md
# Saturating Accumulator ALU with Multiplier

This block is the arithmetic core of a fixed-point signal processor. It holds a 32-bit accumulator, a 16-bit multiplicand (T) register and a 32-bit product register. Each operation arrives as an opcode with a 16-bit data word, a 4-bit left-shift count and a 13-bit immediate. The operation is accepted on a one-cycle valid strobe. The data path covers shifted add, subtract and load. It also covers an add into the upper half only, a conditional subtract step that builds division, absolute value, accumulation of the product, a signed multiply and a few logic operations.

Overflow is detected from the sign bits and recorded in a sticky flag. Only an explicit overflow test clears that flag, and the test reports whether it was taken. When overflow mode is on, an overflowed result clamps to the extreme that matches the sign the accumulator had before the operation. The accumulator's sign and zero conditions come out for branch logic. A 16-bit status word shows the flag and the mode at fixed bit positions.

Top module: `acc_alu_core`

## Requirements
- R1: After reset the accumulator, the product and T are 0, the overflow flag is 0, overflow mode is 1, and the status word reads 0x7EFE. The status word layout is: bit 15 overflow flag, bit 14 overflow mode, bit 13 reads 1, bit 8 reads 0, bit 0 reads 0, and every other bit reads 1.
- R2: Opcode values: 0 idle, 1 shifted add, 2 shifted subtract, 3 shifted load, 4 add-high, 5 conditional subtract, 6 absolute value, 7 add product, 8 subtract product, 9 multiply, 10 multiply immediate, 11 AND, 12 OR, 13 XOR, 14 overflow test, 15 mode set. State changes only at a clock edge where `op_valid` is 1. With `op_valid` at 0, nothing changes.
- R3: The shifted add, subtract and load operations sign-extend the data word to 32 bits and shift it left by `op_shift` (0 to 15).
- R4: An add overflows when the old accumulator and the operand have equal signs and the result's sign differs from them. A subtract overflows when the two input signs differ and the result's sign differs from the old accumulator's. This rule also applies to adding or subtracting the product.
- R5: Any overflow sets the flag, and no arithmetic operation clears it. The overflow test (14) clears the flag only when the flag was set. In that case `ov_taken` is 1 for the cycle after the test; otherwise `ov_taken` is 0.
- R6: With overflow mode at 1, an overflowed add or subtract result becomes 0x80000000 if the old accumulator was negative, and 0x7FFFFFFF otherwise. With overflow mode at 0, the result wraps.
- R7: Add-high adds the unsigned data word to accumulator bits 31:16, and bits 15:0 stay the same. It overflows when the old upper half is non-negative and the new upper half is negative. With overflow mode at 1, the upper half then saturates to 0x7FFF (0x8000 when the old upper half is negative).
- R8: Conditional subtract forms D = accumulator − (zero-extended data << 15). If D ≥ 0 the accumulator becomes (D << 1) + 1; otherwise the accumulator is shifted left by 1. Subtract overflow on D sets the flag, but the result never saturates.
- R9: Absolute value negates a negative accumulator and leaves it unchanged otherwise. With overflow mode at 1, a result of 0x80000000 becomes 0x7FFFFFFF. This operation never changes the flag.
- R10: With `t_load` at 1, T takes the data word at that edge. Multiply stores signed data × signed T in the product register, except that a product of exactly 0x40000000 is stored as 0xC0000000.
- R11: Multiply immediate stores the sign-extended 13-bit immediate × signed T in the product register.
- R12: AND acts on all 32 bits with the zero-extended data word. OR and XOR change only bits 15:0.
- R13: `acc_neg` equals accumulator bit 31, and `acc_zero` is 1 exactly when the accumulator is 0.
- R14: Mode set (15) loads overflow mode from data bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | One-cycle operation strobe |
| op_code | input | 4 | Operation select (R2) |
| op_data | input | 16 | Data operand |
| op_shift | input | 4 | Left shift for shifted operations |
| op_imm | input | 13 | Multiply immediate |
| t_load | input | 1 | Load T from op_data |
| acc_out | output | 32 | Accumulator |
| prod_out | output | 32 | Product register |
| ov_flag | output | 1 | Sticky overflow flag |
| ovm_flag | output | 1 | Overflow (saturation) mode |
| acc_neg | output | 1 | Accumulator negative |
| acc_zero | output | 1 | Accumulator zero |
| ov_taken | output | 1 | Overflow test found the flag set |
| status_word | output | 16 | Status view |

## Verification
The bench targets four groups of corner cases:
- **Saturation.** Sums that cross the positive and the negative limit are tried with the mode on and with it off. A design that keys saturation on the result's sign would clamp to the wrong extreme.
- **Sticky flag.** The flag is checked after later loads and after a second overflow test. A design that clears it on any non-overflowing operation would lose it. A design that clears it on an untaken test would report `ov_taken` falsely.
- **Add-high and conditional subtract.** A lost lower half or a missing carry in the sixteen-step division shows up as a wrong quotient and remainder. So does saturating during the division step.
- **Multiplier and absolute value.** The one remapped product is covered, and so are the absolute value of 0x80000000 in both modes and the high-half behaviour of the logic operations. Each of these exposes a dropped special case.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
   typedef enum logic [3:0] {
      OP_IDLE     = 4'd0,
      OP_ADD_SH   = 4'd1,
      OP_SUB_SH   = 4'd2,
      OP_LOAD_SH  = 4'd3,
      OP_ADD_HI   = 4'd4,
      OP_SUB_COND = 4'd5,
      OP_ABS      = 4'd6,
      OP_ADD_PROD = 4'd7,
      OP_SUB_PROD = 4'd8,
      OP_MUL      = 4'd9,
      OP_MUL_IMM  = 4'd10,
      OP_AND      = 4'd11,
      OP_OR       = 4'd12,
      OP_XOR      = 4'd13,
      OP_OV_TEST  = 4'd14,
      OP_MODE     = 4'd15
   } acc_op_e;

   localparam int unsigned STAT_W      = 16;
   localparam int unsigned STAT_OV_BIT = 15;
   localparam int unsigned STAT_OVM_BIT = 14;
   localparam logic [STAT_W-1:0] STAT_FIXED = 16'h3EFE;
endpackage

// File: rtl/acc_operand_shift.sv
module acc_operand_shift #(
   parameter int unsigned DATA_W  = 16,
   parameter int unsigned SHIFT_W = 4,
   parameter int unsigned ACC_W   = 32
) (
   input  logic [DATA_W-1:0]  data_in,
   input  logic [SHIFT_W-1:0] shift_in,
   output logic [ACC_W-1:0]   operand_out
);
   localparam int unsigned PAD_W = ACC_W - DATA_W;

   generate
      if (DATA_W + (1 << SHIFT_W) - 1 > ACC_W) begin : g_bad_width
         $error("shifted operand does not fit the accumulator");
      end
   endgenerate

   logic [ACC_W-1:0] extended;
   assign extended    = {{PAD_W{data_in[DATA_W-1]}}, data_in};
   assign operand_out = extended << shift_in;
endmodule

// File: rtl/acc_sat_addsub.sv
module acc_sat_addsub #(
   parameter int unsigned W          = 32,
   parameter bit          B_UNSIGNED = 1'b0
) (
   input  logic [W-1:0] a_in,
   input  logic [W-1:0] b_in,
   input  logic         sub_en,
   input  logic         sat_en,
   output logic [W-1:0] res_out,
   output logic         ovf_out
);
   localparam logic [W-1:0] POS_LIM = {1'b0, {(W-1){1'b1}}};
   localparam logic [W-1:0] NEG_LIM = {1'b1, {(W-1){1'b0}}};

   logic [W-1:0] raw;
   logic         b_sign;

   generate
      if (B_UNSIGNED) begin : g_b_unsigned
         assign b_sign = 1'b0;
      end else begin : g_b_signed
         assign b_sign = b_in[W-1];
      end
   endgenerate

   assign raw = sub_en ? (a_in - b_in) : (a_in + b_in);

   always_comb begin
      if (sub_en)
         ovf_out = (a_in[W-1] ^ b_sign) & (a_in[W-1] ^ raw[W-1]);
      else
         ovf_out = ~(a_in[W-1] ^ b_sign) & (a_in[W-1] ^ raw[W-1]);
      if (ovf_out && sat_en)
         res_out = a_in[W-1] ? NEG_LIM : POS_LIM;
      else
         res_out = raw;
   end
endmodule

// File: rtl/acc_product_unit.sv
module acc_product_unit #(
   parameter int unsigned DATA_W   = 16,
   parameter int unsigned IMM_W    = 13,
   parameter bit          REMAP_EN = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  t_load,
   input  logic [DATA_W-1:0]     t_data,
   input  logic                  mul_en,
   input  logic                  imm_sel,
   input  logic [DATA_W-1:0]     mul_data,
   input  logic [IMM_W-1:0]      mul_imm,
   output logic [2*DATA_W-1:0]   prod_out
);
   localparam int unsigned PW = 2 * DATA_W;
   localparam logic [PW-1:0] REMAP_FROM = {2'b01, {(PW-2){1'b0}}};
   localparam logic [PW-1:0] REMAP_TO   = {2'b11, {(PW-2){1'b0}}};

   generate
      if (IMM_W > DATA_W || IMM_W < 2) begin : g_bad_imm
         $error("immediate width out of range");
      end
   endgenerate

   logic [DATA_W-1:0] t_q;
   logic [DATA_W-1:0] mul_b;
   logic [PW-1:0]     full;
   logic [PW-1:0]     prod_d;
   logic [PW-1:0]     prod_q;

   assign mul_b = imm_sel ? {{(DATA_W-IMM_W){mul_imm[IMM_W-1]}}, mul_imm} : mul_data;
   assign full  = $signed({{DATA_W{t_q[DATA_W-1]}}, t_q}) *
                  $signed({{DATA_W{mul_b[DATA_W-1]}}, mul_b});

   generate
      if (REMAP_EN) begin : g_remap
         assign prod_d = (!imm_sel && full == REMAP_FROM) ? REMAP_TO : full;
         assert_no_remap_value_R10: assert property (@(posedge clk) disable iff (!rst_n)
            prod_q != REMAP_FROM);
      end else begin : g_plain
         assign prod_d = full;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         t_q    <= '0;
         prod_q <= '0;
      end else begin
         if (t_load) t_q <= t_data;
         if (mul_en) prod_q <= prod_d;
      end
   end

   assign prod_out = prod_q;
endmodule

// File: rtl/acc_alu_core.sv
module acc_alu_core
   import acc_alu_pkg::*;
#(
   parameter int unsigned DATA_W   = 16,
   parameter int unsigned SHIFT_W  = 4,
   parameter int unsigned IMM_W    = 13,
   parameter bit          REMAP_EN = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  op_valid,
   input  logic [3:0]            op_code,
   input  logic [DATA_W-1:0]     op_data,
   input  logic [SHIFT_W-1:0]    op_shift,
   input  logic [IMM_W-1:0]      op_imm,
   input  logic                  t_load,
   output logic [2*DATA_W-1:0]   acc_out,
   output logic [2*DATA_W-1:0]   prod_out,
   output logic                  ov_flag,
   output logic                  ovm_flag,
   output logic                  acc_neg,
   output logic                  acc_zero,
   output logic                  ov_taken,
   output logic [15:0]           status_word
);
   localparam int unsigned ACC_W = 2 * DATA_W;
   localparam logic [ACC_W-1:0] ACC_MIN = {1'b1, {(ACC_W-1){1'b0}}};
   localparam logic [ACC_W-1:0] ACC_MAX = {1'b0, {(ACC_W-1){1'b1}}};

   acc_op_e op;
   assign op = acc_op_e'(op_code);

   logic [ACC_W-1:0] acc_q, acc_d;
   logic             ov_q, ovm_q, taken_q, ov_set;
   logic [ACC_W-1:0] shifted, prod_w, main_b, main_res, cond_b, cond_res;
   logic [DATA_W-1:0] hi_res;
   logic             main_ovf, cond_ovf, hi_ovf, main_sub, is_test;
   logic [ACC_W-1:0] neg_acc;

   acc_operand_shift #(.DATA_W(DATA_W), .SHIFT_W(SHIFT_W), .ACC_W(ACC_W)) u_shift (
      .data_in(op_data), .shift_in(op_shift), .operand_out(shifted));

   assign main_b   = (op == OP_ADD_PROD || op == OP_SUB_PROD) ? prod_w : shifted;
   assign main_sub = (op == OP_SUB_SH || op == OP_SUB_PROD);

   acc_sat_addsub #(.W(ACC_W), .B_UNSIGNED(1'b0)) u_main (
      .a_in(acc_q), .b_in(main_b), .sub_en(main_sub), .sat_en(ovm_q),
      .res_out(main_res), .ovf_out(main_ovf));

   acc_sat_addsub #(.W(DATA_W), .B_UNSIGNED(1'b1)) u_high (
      .a_in(acc_q[ACC_W-1:DATA_W]), .b_in(op_data), .sub_en(1'b0), .sat_en(ovm_q),
      .res_out(hi_res), .ovf_out(hi_ovf));

   assign cond_b = {{DATA_W{1'b0}}, op_data} << (DATA_W - 1);

   acc_sat_addsub #(.W(ACC_W), .B_UNSIGNED(1'b0)) u_cond (
      .a_in(acc_q), .b_in(cond_b), .sub_en(1'b1), .sat_en(1'b0),
      .res_out(cond_res), .ovf_out(cond_ovf));

   acc_product_unit #(.DATA_W(DATA_W), .IMM_W(IMM_W), .REMAP_EN(REMAP_EN)) u_prod (
      .clk(clk), .rst_n(rst_n), .t_load(t_load), .t_data(op_data),
      .mul_en(op_valid && (op == OP_MUL || op == OP_MUL_IMM)),
      .imm_sel(op == OP_MUL_IMM), .mul_data(op_data), .mul_imm(op_imm),
      .prod_out(prod_w));

   assign neg_acc = -acc_q;
   assign is_test = op_valid && (op == OP_OV_TEST);

   always_comb begin
      acc_d  = acc_q;
      ov_set = 1'b0;
      case (op)
         OP_ADD_SH, OP_SUB_SH, OP_ADD_PROD, OP_SUB_PROD: begin
            acc_d  = main_res;
            ov_set = main_ovf;
         end
         OP_LOAD_SH: acc_d = shifted;
         OP_ADD_HI: begin
            acc_d  = {hi_res, acc_q[DATA_W-1:0]};
            ov_set = hi_ovf;
         end
         OP_SUB_COND: begin
            acc_d  = cond_res[ACC_W-1] ? (acc_q << 1) : ((cond_res << 1) | 1);
            ov_set = cond_ovf;
         end
         OP_ABS: begin
            if (acc_q[ACC_W-1])
               acc_d = (ovm_q && neg_acc == ACC_MIN) ? ACC_MAX : neg_acc;
         end
         OP_AND: acc_d = acc_q & {{DATA_W{1'b0}}, op_data};
         OP_OR:  acc_d = {acc_q[ACC_W-1:DATA_W], acc_q[DATA_W-1:0] | op_data};
         OP_XOR: acc_d = {acc_q[ACC_W-1:DATA_W], acc_q[DATA_W-1:0] ^ op_data};
         default: acc_d = acc_q;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q   <= '0;
         ov_q    <= 1'b0;
         ovm_q   <= 1'b1;
         taken_q <= 1'b0;
      end else begin
         taken_q <= is_test && ov_q;
         if (op_valid) acc_q <= acc_d;
         if (is_test && ov_q) ov_q <= 1'b0;
         else if (op_valid && ov_set) ov_q <= 1'b1;
         if (op_valid && op == OP_MODE) ovm_q <= op_data[0];
      end
   end

   assign acc_out   = acc_q;
   assign prod_out  = prod_w;
   assign ov_flag   = ov_q;
   assign ovm_flag  = ovm_q;
   assign acc_neg   = acc_q[ACC_W-1];
   assign acc_zero  = (acc_q == '0);
   assign ov_taken  = taken_q;
   always_comb begin
      status_word = STAT_FIXED;
      status_word[STAT_OV_BIT]  = ov_q;
      status_word[STAT_OVM_BIT] = ovm_q;
   end

   assert_ov_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (ov_q && !is_test) |=> ov_q);
   assert_test_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
      taken_q |-> !ov_q);
   assert_load_keeps_ov_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op == OP_LOAD_SH) |=> (ov_q == $past(ov_q)));
   assert_abs_nonneg_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op == OP_ABS && ovm_q) |=> !acc_q[ACC_W-1]);
   assert_addhi_low_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op == OP_ADD_HI) |=> (acc_q[DATA_W-1:0] == $past(acc_q[DATA_W-1:0])));
endmodule

// File: tb/acc_alu_core_bench.sv
module acc_alu_core_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        op_valid = 1'b0;
   logic [3:0]  op_code = 4'd0;
   logic [15:0] op_data = 16'd0;
   logic [3:0]  op_shift = 4'd0;
   logic [12:0] op_imm = 13'd0;
   logic        t_load = 1'b0;
   logic [31:0] acc_out, prod_out;
   logic        ov_flag, ovm_flag, acc_neg, acc_zero, ov_taken;
   logic [15:0] status_word;

   int checks = 0;
   int failures = 0;

   logic [31:0] m_acc = 0, m_prod = 0;
   logic [15:0] m_t = 0;
   logic        m_ov = 0, m_ovm = 1, m_taken = 0;

   always #5 clk = ~clk;

   acc_alu_core u_acc_alu_core (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
      .op_data(op_data), .op_shift(op_shift), .op_imm(op_imm), .t_load(t_load),
      .acc_out(acc_out), .prod_out(prod_out), .ov_flag(ov_flag), .ovm_flag(ovm_flag),
      .acc_neg(acc_neg), .acc_zero(acc_zero), .ov_taken(ov_taken),
      .status_word(status_word));

   task automatic check(input string tag, input string what, input logic [31:0] act,
                        input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic check_all(input string tag);
      check(tag, "acc", acc_out, m_acc);
      check(tag, "prod", prod_out, m_prod);
      check(tag, "ov", {31'd0, ov_flag}, {31'd0, m_ov});
      check(tag, "ovm", {31'd0, ovm_flag}, {31'd0, m_ovm});
      check("R13", "neg", {31'd0, acc_neg}, {31'd0, m_acc[31]});
      check("R13", "zero", {31'd0, acc_zero}, {31'd0, m_acc == 0});
      check("R5", "taken", {31'd0, ov_taken}, {31'd0, m_taken});
      check("R1", "status", {16'd0, status_word}, {16'd0, m_ov, m_ovm, 14'h3EFE});
   endtask

   // reference model built from the requirement text
   task automatic model(input logic [3:0] op, input logic [15:0] d, input logic [3:0] sh,
                        input logic [12:0] imm);
      logic [31:0] b, r, full;
      logic [15:0] h;
      logic ovf;
      logic [31:0] sx;
      sx = {{16{d[15]}}, d} << sh;
      ovf = 0;
      m_taken = 0;
      case (op)
         4'd1, 4'd2, 4'd7, 4'd8: begin
            b = (op == 4'd7 || op == 4'd8) ? m_prod : sx;
            if (op == 4'd1 || op == 4'd7) begin
               r = m_acc + b;
               ovf = (m_acc[31] == b[31]) && (r[31] != m_acc[31]);
            end else begin
               r = m_acc - b;
               ovf = (m_acc[31] != b[31]) && (r[31] != m_acc[31]);
            end
            if (ovf && m_ovm) r = m_acc[31] ? 32'h80000000 : 32'h7FFFFFFF;
            m_acc = r;
         end
         4'd3: m_acc = sx;
         4'd4: begin
            h = m_acc[31:16] + d;
            ovf = !m_acc[31] && h[15];
            if (ovf && m_ovm) h = 16'h7FFF;
            m_acc = {h, m_acc[15:0]};
         end
         4'd5: begin
            b = {16'd0, d} << 15;
            r = m_acc - b;
            ovf = m_acc[31] && !r[31];
            m_acc = r[31] ? (m_acc << 1) : ((r << 1) + 1);
         end
         4'd6: if (m_acc[31]) begin
            r = 32'd0 - m_acc;
            m_acc = (m_ovm && r == 32'h80000000) ? 32'h7FFFFFFF : r;
         end
         4'd9: begin
            full = 32'($signed(m_t) * $signed(d));
            m_prod = (full == 32'h40000000) ? 32'hC0000000 : full;
         end
         4'd10: m_prod = 32'($signed(m_t) * $signed({{3{imm[12]}}, imm}));
         4'd11: m_acc = m_acc & {16'd0, d};
         4'd12: m_acc[15:0] = m_acc[15:0] | d;
         4'd13: m_acc[15:0] = m_acc[15:0] ^ d;
         4'd14: if (m_ov) begin m_ov = 0; m_taken = 1; end
         4'd15: m_ovm = d[0];
         default: ;
      endcase
      if (ovf) m_ov = 1;
   endtask

   task automatic run_op(input logic [3:0] op, input logic [15:0] d, input logic [3:0] sh,
                         input logic [12:0] imm);
      op_code = op; op_data = d; op_shift = sh; op_imm = imm; op_valid = 1'b1;
      @(negedge clk);
      op_valid = 1'b0;
      model(op, d, sh, imm);
   endtask

   task automatic load_t(input logic [15:0] d);
      op_data = d; t_load = 1'b1;
      @(negedge clk);
      t_load = 1'b0;
      m_t = d;
      m_taken = 0;
   endtask

   task automatic t_reset_state();
      check_all("R1");
      check("R1", "status reset", {16'd0, status_word}, 32'h00007EFE);
   endtask

   task automatic t_strobe();
      run_op(4'd3, 16'h1234, 4'd0, 0);
      op_code = 4'd3; op_data = 16'h5555; op_valid = 1'b0;
      @(negedge clk);
      m_taken = 0;
      check("R2", "acc without strobe", acc_out, 32'h00001234);
      run_op(4'd3, 16'h8001, 4'd4, 0);
      check("R3", "shifted load", acc_out, 32'hFFF80010);
      check_all("R3");
      run_op(4'd1, 16'h0003, 4'd2, 0);
      check_all("R3");
      run_op(4'd3, 16'h0000, 4'd0, 0);
      check("R13", "zero", {31'd0, acc_zero}, 32'd1);
   endtask

   task automatic t_wrap_sticky();
      run_op(4'd15, 16'h0000, 0, 0);
      check_all("R14");
      run_op(4'd3, 16'h7FFF, 4'd15, 0);
      run_op(4'd1, 16'h7FFF, 4'd15, 0);
      check("R4", "no ovf", {31'd0, ov_flag}, 32'd0);
      run_op(4'd1, 16'h7FFF, 4'd15, 0);
      check("R6", "wrap", acc_out, 32'hBFFE8000);
      check("R4", "ovf set", {31'd0, ov_flag}, 32'd1);
      run_op(4'd3, 16'h0000, 4'd0, 0);
      check("R5", "sticky after load", {31'd0, ov_flag}, 32'd1);
      run_op(4'd14, 0, 0, 0);
      check("R5", "taken", {31'd0, ov_taken}, 32'd1);
      check_all("R5");
      run_op(4'd14, 0, 0, 0);
      check("R5", "not taken", {31'd0, ov_taken}, 32'd0);
      check_all("R5");
   endtask

   task automatic t_saturate();
      run_op(4'd15, 16'h0001, 0, 0);
      run_op(4'd3, 16'h7FFF, 4'd15, 0);
      run_op(4'd1, 16'h7FFF, 4'd15, 0);
      run_op(4'd1, 16'h7FFF, 4'd15, 0);
      check("R6", "sat pos", acc_out, 32'h7FFFFFFF);
      check_all("R6");
      run_op(4'd3, 16'h8000, 4'd15, 0);
      run_op(4'd2, 16'h7FFF, 4'd15, 0);
      check("R4", "sub no ovf", acc_out, 32'h80008000);
      run_op(4'd2, 16'h7FFF, 4'd15, 0);
      check("R6", "sat neg", acc_out, 32'h80000000);
      check_all("R6");
      run_op(4'd14, 0, 0, 0);
   endtask

   task automatic t_add_high();
      run_op(4'd3, 16'h1234, 4'd0, 0);
      run_op(4'd4, 16'h7FFF, 4'd0, 0);
      check("R7", "addh", acc_out, 32'h7FFF1234);
      run_op(4'd4, 16'h0001, 4'd0, 0);
      check("R7", "addh sat", acc_out, 32'h7FFF1234);
      check("R7", "addh ov", {31'd0, ov_flag}, 32'd1);
      run_op(4'd15, 16'h0000, 0, 0);
      run_op(4'd4, 16'h0001, 4'd0, 0);
      check("R7", "addh wrap", acc_out, 32'h80001234);
      run_op(4'd4, 16'hFFFF, 4'd0, 0);
      check_all("R7");
      run_op(4'd14, 0, 0, 0);
   endtask

   task automatic t_cond_sub();
      run_op(4'd3, 16'h0007, 4'd0, 0);
      for (int i = 0; i < 16; i++) run_op(4'd5, 16'h0002, 0, 0);
      check("R8", "7/2 quotient and remainder", acc_out, 32'h00010003);
      check_all("R8");
      run_op(4'd15, 16'h0001, 0, 0);
      run_op(4'd3, 16'h8000, 4'd15, 0);
      run_op(4'd1, 16'h8000, 4'd15, 0);
      run_op(4'd5, 16'h7FFF, 0, 0);
      check("R8", "no saturation", acc_out, 32'h80010001);
      check("R8", "ov set", {31'd0, ov_flag}, 32'd1);
      check_all("R8");
      run_op(4'd14, 0, 0, 0);
   endtask

   task automatic t_abs();
      run_op(4'd3, 16'hFFFB, 4'd0, 0);
      run_op(4'd6, 0, 0, 0);
      check("R9", "abs -5", acc_out, 32'h00000005);
      run_op(4'd6, 0, 0, 0);
      check("R9", "abs positive", acc_out, 32'h00000005);
      run_op(4'd3, 16'h8000, 4'd15, 0);
      run_op(4'd1, 16'h8000, 4'd15, 0);
      run_op(4'd6, 0, 0, 0);
      check("R9", "abs min sat", acc_out, 32'h7FFFFFFF);
      check("R9", "abs flag", {31'd0, ov_flag}, 32'd0);
      run_op(4'd15, 16'h0000, 0, 0);
      run_op(4'd3, 16'h8000, 4'd15, 0);
      run_op(4'd1, 16'h8000, 4'd15, 0);
      run_op(4'd6, 0, 0, 0);
      check("R9", "abs min wrap", acc_out, 32'h80000000);
      check_all("R9");
   endtask

   task automatic t_multiply();
      load_t(16'h8000);
      run_op(4'd9, 16'h8000, 0, 0);
      check("R10", "remap", prod_out, 32'hC0000000);
      run_op(4'd9, 16'h0001, 0, 0);
      check("R10", "mul", prod_out, 32'hFFFF8000);
      load_t(16'h0064);
      run_op(4'd10, 0, 0, 13'h1FFF);
      check("R11", "mul imm", prod_out, 32'hFFFFFF9C);
      run_op(4'd9, 16'hFFFE, 0, 0);
      run_op(4'd3, 16'h0000, 4'd0, 0);
      run_op(4'd7, 0, 0, 0);
      check("R4", "add prod", acc_out, 32'hFFFFFF38);
      run_op(4'd8, 0, 0, 0);
      check_all("R4");
      load_t(16'h7FFF);
      run_op(4'd9, 16'h7FFF, 0, 0);
      run_op(4'd15, 16'h0001, 0, 0);
      run_op(4'd3, 16'h7FFF, 4'd15, 0);
      run_op(4'd1, 16'h7FFF, 4'd15, 0);
      run_op(4'd7, 0, 0, 0);
      check("R6", "add prod sat", acc_out, 32'h7FFFFFFF);
      check_all("R6");
      run_op(4'd14, 0, 0, 0);
   endtask

   task automatic t_logic();
      run_op(4'd3, 16'h9234, 4'd0, 0);
      run_op(4'd11, 16'h00FF, 0, 0);
      check("R12", "and", acc_out, 32'h00000034);
      run_op(4'd3, 16'h8000, 4'd15, 0);
      run_op(4'd12, 16'h00F0, 0, 0);
      check("R12", "or", acc_out, 32'hC00000F0);
      run_op(4'd13, 16'h0FF0, 0, 0);
      check("R12", "xor", acc_out, 32'hC0000F00);
      check_all("R12");
   endtask

   initial begin
      #1_000_000;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset_state();
      t_strobe();
      t_wrap_sticky();
      t_saturate();
      t_add_high();
      t_cond_sub();
      t_abs();
      t_multiply();
      t_logic();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule